// File: doc/BRIEF.md
# Multi-Mode Operand Address Resolver

This block is the operand-fetch stage of an accumulator machine. For each request it takes a mode code, a 10-bit constant-or-address field and a 4-bit register selector. It resolves the operand under one of seven addressing modes and returns the operand value with a one-cycle `done_o` pulse. It reads a 16-entry register file through a combinational read port. It also reads a single-port word memory whose data returns one cycle after the read strobe. A pointer-chasing mode needs two memory reads, and the block issues them itself.

Immediate and register operands finish in the request cycle. Modes that need one memory word finish one cycle after the request. Memory-indirect finishes two cycles after it. While a memory read is outstanding, `ready_o` is low and any request is ignored.

The controller has four states:
- `ST_IDLE` accepts requests.
- `ST_FETCH` waits for the final data of a single-read mode.
- `ST_PTR` waits for the pointer word and issues the second read.
- `ST_DEREF` waits for the final data of memory-indirect.

Its transitions are:
- IDLE→IDLE, for no request or a same-cycle mode.
- IDLE→FETCH, for direct, register-indirect, indexed or based.
- IDLE→PTR, for memory-indirect.
- PTR→DEREF.
- FETCH→IDLE.
- DEREF→IDLE.

Top module: `opres_resolver`

## Requirements
- R1: Mode code 0 (immediate) completes in the request cycle: `done_o`=1, `operand_o` = field zero-extended, `mem_rd_o`=0.
- R2: Mode code 2 (register) completes in the request cycle with `rf_sel_o` = `rsel_i` and `operand_o` equal to the register-file read data, with no memory read.
- R3: Mode code 1 (direct) reads memory at the field address in the request cycle; one cycle later `done_o`=1 and `operand_o` is that word.
- R4: Mode code 3 (memory-indirect) reads at the field address, then in the next cycle reads at the low 10 bits of the returned word without `done_o`; one cycle after that `done_o`=1 with the second word.
- R5: Mode code 4 (register-indirect) reads memory at the low 10 bits of the selected register and completes one cycle later with that word.
- R6: Mode codes 5 (indexed) and 6 (based) read at (field + low 10 bits of the selected register) modulo 1024 and complete one cycle later with that word.
- R7: `ready_o` is high only in the idle state; a request while `ready_o` is low causes no read, no `done_o` and no change to the operand being resolved.
- R8: Every accepted request yields exactly one `done_o` cycle.
- R9: Mode code 7 is treated as immediate.
- R10: After reset `ready_o`=1, `done_o`=0 and `mem_rd_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Operand request, accepted when `ready_o` is high |
| mode_i | input | 3 | Addressing mode code |
| field_i | input | 10 | Constant, address or displacement field |
| rsel_i | input | 4 | Register selector |
| ready_o | output | 1 | Idle, a request is accepted this cycle |
| done_o | output | 1 | Operand valid pulse |
| operand_o | output | 16 | Resolved operand |
| rf_sel_o | output | 4 | Register-file read index |
| rf_data_i | input | 16 | Register-file read data |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 10 | Memory read address |
| mem_rdata_i | input | 16 | Memory read data, one cycle after the strobe |

## Verification
The bench builds the block with its defaults: a 10-bit address, 16-bit data and 4-bit register selector. With these values the full 1024-word memory and all 16 registers are modelled. Random fields and register contents therefore reach the wrap of indexed and based sums past the top address. Pointer words have random upper bits, so the second read of the indirect mode shows whether those bits are truncated.

// File: rtl/opres_pkg.sv
package opres_pkg;

    typedef enum logic [2:0] {
        M_IMM  = 3'd0,
        M_DIR  = 3'd1,
        M_REG  = 3'd2,
        M_MIND = 3'd3,
        M_RIND = 3'd4,
        M_IDX  = 3'd5,
        M_BASE = 3'd6,
        M_RSVD = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PTR,
        ST_DEREF
    } ostate_e;

    // number of memory reads a mode needs
    typedef enum logic [1:0] {
        K_NOW,
        K_ONE,
        K_TWO
    } kind_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_FIELD,
        SRC_REG,
        SRC_MEM
    } opsrc_e;

endpackage

// File: rtl/opres_decode.sv
module opres_decode
    import opres_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  amode_e              mode,
    input  logic [ADDR_W-1:0]   field,
    input  logic [ADDR_W-1:0]   reg_lo,
    output kind_e               kind,
    output opsrc_e              src_now,
    output logic [ADDR_W-1:0]   first_addr
);

    logic [ADDR_W-1:0] sum_addr;

    // modulo 2**ADDR_W by truncation
    assign sum_addr = field + reg_lo;

    always_comb begin
        kind       = K_NOW;
        src_now    = SRC_NONE;
        first_addr = field;
        unique case (mode)
            M_IMM, M_RSVD: begin
                kind    = K_NOW;
                src_now = SRC_FIELD;
            end
            M_REG: begin
                kind    = K_NOW;
                src_now = SRC_REG;
            end
            M_DIR: begin
                kind       = K_ONE;
                first_addr = field;
            end
            M_MIND: begin
                kind       = K_TWO;
                first_addr = field;
            end
            M_RIND: begin
                kind       = K_ONE;
                first_addr = reg_lo;
            end
            M_IDX, M_BASE: begin
                kind       = K_ONE;
                first_addr = sum_addr;
            end
        endcase
    end

endmodule

// File: rtl/opres_fsm.sv
module opres_fsm
    import opres_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  kind_e             kind,
    input  opsrc_e            src_now,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] ptr_word,
    output logic              ready,
    output logic              done,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output opsrc_e            src
);

    ostate_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req && kind == K_ONE)      state_d = ST_FETCH;
                else if (req && kind == K_TWO) state_d = ST_PTR;
            end
            ST_FETCH: state_d = ST_IDLE;
            ST_PTR:   state_d = ST_DEREF;
            ST_DEREF: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ready    = 1'b0;
        done     = 1'b0;
        mem_rd   = 1'b0;
        mem_addr = first_addr;
        src      = SRC_NONE;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
                if (req) begin
                    if (kind == K_NOW) begin
                        done = 1'b1;
                        src  = src_now;
                    end else begin
                        mem_rd = 1'b1;
                    end
                end
            end
            ST_FETCH, ST_DEREF: begin
                done = 1'b1;
                src  = SRC_MEM;
            end
            ST_PTR: begin
                mem_rd   = 1'b1;
                mem_addr = ptr_word;
            end
        endcase
    end

endmodule

// File: rtl/opres_opmux.sv
module opres_opmux
    import opres_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  opsrc_e            src,
    input  logic [ADDR_W-1:0] field,
    input  logic [DATA_W-1:0] reg_data,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] operand
);

    always_comb begin
        unique case (src)
            SRC_FIELD: operand = DATA_W'(field);
            SRC_REG:   operand = reg_data;
            SRC_MEM:   operand = mem_data;
            SRC_NONE:  operand = '0;
        endcase
    end

endmodule

// File: rtl/opres_resolver.sv
module opres_resolver
    import opres_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int RSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [2:0]        mode_i,
    input  logic [ADDR_W-1:0] field_i,
    input  logic [RSEL_W-1:0] rsel_i,
    output logic              ready_o,
    output logic              done_o,
    output logic [DATA_W-1:0] operand_o,
    output logic [RSEL_W-1:0] rf_sel_o,
    input  logic [DATA_W-1:0] rf_data_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);

    kind_e             kind;
    opsrc_e            src_now;
    opsrc_e            src;
    logic [ADDR_W-1:0] first_addr;
    amode_e            mode;

    assign mode     = amode_e'(mode_i);
    assign rf_sel_o = rsel_i;

    opres_decode #(.ADDR_W(ADDR_W)) u_dec (
        .mode       (mode),
        .field      (field_i),
        .reg_lo     (rf_data_i[ADDR_W-1:0]),
        .kind       (kind),
        .src_now    (src_now),
        .first_addr (first_addr)
    );

    opres_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req_i),
        .kind       (kind),
        .src_now    (src_now),
        .first_addr (first_addr),
        .ptr_word   (mem_rdata_i[ADDR_W-1:0]),
        .ready      (ready_o),
        .done       (done_o),
        .mem_rd     (mem_rd_o),
        .mem_addr   (mem_addr_o),
        .src        (src)
    );

    opres_opmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .src      (src),
        .field    (field_i),
        .reg_data (rf_data_i),
        .mem_data (mem_rdata_i),
        .operand  (operand_o)
    );

endmodule

// File: rtl/opres_resolver_chk.sv
module opres_resolver_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int RSEL_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic [2:0]        mode_i,
    input logic [ADDR_W-1:0] field_i,
    input logic [RSEL_W-1:0] rsel_i,
    input logic              ready_o,
    input logic              done_o,
    input logic [DATA_W-1:0] operand_o,
    input logic [RSEL_W-1:0] rf_sel_o,
    input logic [DATA_W-1:0] rf_data_i,
    input logic              mem_rd_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_rdata_i
);

    logic acc;
    assign acc = req_i && ready_o;

    p_imm_now_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (mode_i == 3'd0 || mode_i == 3'd7) |-> done_o && !mem_rd_o
            && operand_o == DATA_W'(field_i));

    p_reg_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc && mode_i == 3'd2 |-> done_o && !mem_rd_o && rf_sel_o == rsel_i
            && operand_o == rf_data_i);

    p_direct_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && mode_i == 3'd1 |-> mem_rd_o && !done_o && mem_addr_o == field_i);

    p_single_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (mode_i == 3'd1 || mode_i == 3'd4 || mode_i == 3'd5 || mode_i == 3'd6)
            |=> done_o && operand_o == mem_rdata_i && !mem_rd_o);

    p_indirect_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc && mode_i == 3'd3 |=> mem_rd_o && !done_o
            && mem_addr_o == mem_rdata_i[ADDR_W-1:0]);

    p_indexed_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (mode_i == 3'd5 || mode_i == 3'd6) |-> mem_rd_o
            && mem_addr_o == ADDR_W'(field_i + rf_data_i[ADDR_W-1:0]));

    p_busy_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o && !ready_o |=> done_o && !ready_o);

    p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !ready_o |=> ready_o);

    p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ready_o);

endmodule

bind opres_resolver opres_resolver_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RSEL_W(RSEL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
    .field_i(field_i), .rsel_i(rsel_i), .ready_o(ready_o), .done_o(done_o),
    .operand_o(operand_o), .rf_sel_o(rf_sel_o), .rf_data_i(rf_data_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i)
);

// File: tb/opres_resolver_tb.sv
module opres_resolver_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 16;
    localparam int RSEL_W = 4;
    localparam int MEM_N  = 1 << ADDR_W;
    localparam int REG_N  = 1 << RSEL_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_i = 1'b0;
    logic [2:0]        mode_i = '0;
    logic [ADDR_W-1:0] field_i = '0;
    logic [RSEL_W-1:0] rsel_i = '0;
    logic              ready_o, done_o, mem_rd_o;
    logic [DATA_W-1:0] operand_o, rf_data_i;
    logic [DATA_W-1:0] mem_rdata_i = '0;
    logic [RSEL_W-1:0] rf_sel_o;
    logic [ADDR_W-1:0] mem_addr_o;

    logic [DATA_W-1:0] mem [MEM_N];
    logic [DATA_W-1:0] regs [REG_N];

    int checks = 0;
    int errors = 0;
    int accepted = 0;
    int done_seen = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opres_resolver #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RSEL_W(RSEL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
        .field_i(field_i), .rsel_i(rsel_i), .ready_o(ready_o), .done_o(done_o),
        .operand_o(operand_o), .rf_sel_o(rf_sel_o), .rf_data_i(rf_data_i),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i)
    );

    assign rf_data_i = regs[rf_sel_o];

    always @(posedge clk) if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
    always @(posedge clk) if (rst_n && done_o) done_seen++;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] first_addr(input int m, input logic [ADDR_W-1:0] f,
                                                       input logic [RSEL_W-1:0] r);
        case (m)
            4:       return regs[r][ADDR_W-1:0];
            5, 6:    return ADDR_W'(f + regs[r][ADDR_W-1:0]);
            default: return f;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] exp_operand(input int m, input logic [ADDR_W-1:0] f,
                                                       input logic [RSEL_W-1:0] r);
        case (m)
            0, 7:    return DATA_W'(f);
            2:       return regs[r];
            3:       return mem[mem[f][ADDR_W-1:0]];
            default: return mem[first_addr(m, f, r)];
        endcase
    endfunction

    function automatic string tag(input int m);
        case (m)
            0: return "R1";
            1: return "R3";
            2: return "R2";
            3: return "R4";
            4: return "R5";
            7: return "R9";
            default: return "R6";
        endcase
    endfunction

    // busy_hold: keep req_i high with an immediate request while busy (R7)
    task automatic do_req(input int m, input logic [ADDR_W-1:0] f,
                          input logic [RSEL_W-1:0] r, input bit busy_hold);
        logic [DATA_W-1:0] expv;
        expv = exp_operand(m, f, r);
        @(negedge clk);
        req_i = 1'b1; mode_i = 3'(m); field_i = f; rsel_i = r;
        #1;
        accepted++;
        chk(ready_o == 1'b1, "R7", int'(ready_o), 1);
        if (m == 0 || m == 2 || m == 7) begin
            chk(done_o && operand_o == expv && !mem_rd_o, tag(m), int'(operand_o), int'(expv));
            @(negedge clk);
            req_i = 1'b0;
            #1;
            chk(!done_o && ready_o, "R8", int'(done_o), 0);
        end else begin
            chk(mem_rd_o && !done_o && mem_addr_o == first_addr(m, f, r), tag(m),
                int'(mem_addr_o), int'(first_addr(m, f, r)));
            @(negedge clk);
            if (busy_hold) begin
                mode_i = 3'd0; field_i = ~f;
            end else begin
                req_i = 1'b0;
            end
            #1;
            chk(!ready_o, "R7", int'(ready_o), 0);
            if (m == 3) begin
                chk(mem_rd_o && !done_o && mem_addr_o == mem[f][ADDR_W-1:0], "R4",
                    int'(mem_addr_o), int'(mem[f][ADDR_W-1:0]));
                @(negedge clk);
                #1;
                chk(!ready_o, "R7", int'(ready_o), 0);
            end
            chk(done_o && operand_o == expv && !mem_rd_o, tag(m), int'(operand_o), int'(expv));
            req_i = 1'b0;
            @(negedge clk);
            #1;
            chk(!done_o && ready_o && !mem_rd_o, "R8", int'(done_o), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEM_N; i++) mem[i] = DATA_W'($urandom);
        for (int i = 0; i < REG_N; i++) regs[i] = DATA_W'($urandom);
        regs[3] = 16'hA3FF;
        regs[9] = 16'h0000;

        repeat (3) @(negedge clk);
        #1;
        chk(ready_o && !done_o && !mem_rd_o, "R10", int'({ready_o, done_o, mem_rd_o}), 4);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(ready_o && !done_o && !mem_rd_o, "R10", int'({ready_o, done_o, mem_rd_o}), 4);

        // directed corner cases
        do_req(0, 10'h3FF, 4'd0, 1'b0);      // R1 widest constant
        do_req(7, 10'h155, 4'd0, 1'b0);      // R9 reserved code
        do_req(2, 10'h000, 4'd3, 1'b0);      // R2
        do_req(1, 10'h000, 4'd0, 1'b0);      // R3 lowest address
        do_req(1, 10'h3FF, 4'd0, 1'b0);      // R3 highest address
        mem[10'h012] = 16'hFC05;             // R4 pointer with upper bits set
        mem[10'h005] = 16'hBEEF;
        do_req(3, 10'h012, 4'd0, 1'b0);
        do_req(4, 10'h000, 4'd3, 1'b0);      // R5 register holds 0x3FF in low bits
        do_req(5, 10'h3FF, 4'd3, 1'b0);      // R6 wrap: 0x3FF+0x3FF -> 0x3FE
        do_req(6, 10'h001, 4'd3, 1'b0);      // R6 wrap: 0x3FF+1 -> 0
        do_req(5, 10'h123, 4'd9, 1'b0);      // R6 zero index
        do_req(3, 10'h012, 4'd0, 1'b1);      // R7 request held while busy
        do_req(1, 10'h2A0, 4'd0, 1'b1);      // R7

        // constrained random
        for (int n = 0; n < 400; n++) begin
            do_req(int'($urandom % 8), ADDR_W'($urandom), RSEL_W'($urandom),
                   ($urandom % 4) == 0);
        end

        @(negedge clk);
        chk(done_seen == accepted, "R8", done_seen, accepted);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule